// File: doc/BRIEF.md
# ASID-Tagged Address Translation Buffer

This block is a small, fully associative translation cache. It turns a 32-bit virtual address into a physical address, using 4 KB pages. Every stored mapping is tagged with an address-space identifier, so mappings from several processes can share the array, and a process switch does not require a flush. A lookup request carries the virtual address, the current identifier and a write flag. One cycle later the block returns hit or miss, the physical address and a protection-fault flag.

On a miss, the surrounding logic walks the page tables and installs the mapping through the fill port. The block picks the slot to replace. When that slot held a live mapping, the block reports the replaced page and whether it was modified. An invalidate port clears either every mapping or only those of one identifier.

A register holds the most recent translation. A repeated access to the same page is answered from this register instead of the associative search.

Top module: `tlb_asid_xlat`

## Requirements
- R1: The virtual page number is `req_vaddr[31:12]`. On a hit, `rsp_paddr` is the stored physical page number with `req_vaddr[11:0]` appended unchanged below it. On a miss or a fault, `rsp_paddr` is 0.
- R2: A lookup hits only when an entry is valid, its virtual page number equals the request's, and its identifier equals `req_asid`. A request under another identifier misses, and the entries of other identifiers remain usable afterwards.
- R3: A write that hits an entry marks that entry modified. When the entry is later replaced, `evict_dirty` reads 1. An entry that was only read reports 0.
- R4: A hit sets the entry's used bit, and a fill clears the used bit of the new entry. The fill slot is chosen in this order: the lowest-index invalid entry; otherwise the lowest-index entry whose used bit is clear; otherwise entry 0, and in that last case every used bit is cleared.
- R5: A write that matches an entry whose permission bit is 0 (read-only) gives `rsp_fault`=1 and `rsp_hit`=0. It sets neither the used bit nor the modified bit. A read of such an entry is a normal hit. An entry filled with `fill_writable`=1 accepts writes.
- R6: The last-translation register answers a repeated lookup of the same page and identifier with the same result the array would give. An invalidate or a fill clears the register, so a mapping removed by an invalidate misses on its next lookup.
- R7: `rsp_valid` and the lookup result appear in the cycle after `req_valid`. A fill or an invalidate takes effect at the next clock edge, so a lookup in the following cycle sees it. After reset, `rsp_valid` and `evict_valid` are 0.
- R8: An invalidate with `inv_all`=1 clears every entry. With `inv_all`=0 it clears only the entries whose identifier equals `inv_asid`.
- R9: In the cycle after a fill that replaces a valid entry, `evict_valid` is 1, and `evict_vpn`, `evict_asid` and `evict_dirty` describe the replaced entry. If the chosen slot was invalid, `evict_valid` stays 0.
- R10: An invalidate and a fill requested in the same cycle perform only the invalidate. The fill is dropped and reports no eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Current address-space identifier |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Lookup result is present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_paddr | output | 32 | Translated physical address |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_asid | input | 8 | Identifier of the new mapping |
| fill_ppn | input | 20 | Physical page number to install |
| fill_writable | input | 1 | New mapping permits writes |
| inv_valid | input | 1 | Invalidate request |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid | input | 8 | Identifier to invalidate when not all |
| evict_valid | output | 1 | A valid entry was replaced by the last fill |
| evict_vpn | output | 20 | Page number of the replaced entry |
| evict_asid | output | 8 | Identifier of the replaced entry |
| evict_dirty | output | 1 | Replaced entry had been written |

## Verification
The assertions check properties that must hold in every cycle:
- a response follows every request by exactly one cycle;
- a hit and a fault never occur together;
- at most one entry matches a lookup;
- a fill lands in the chosen slot;
- an invalidate empties the last-translation register;
- an eviction report only follows an accepted fill.

Other behaviour only shows up when the bench drives a scenario and compares against its associative model, because it depends on history:
- the replacement order across used bits, including the wrap to entry 0 that clears every used bit;
- modified bits that survive until eviction;
- faults that leave an entry's bits unchanged;
- identifiers that keep their entries while another identifier is cleared.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W   = 32;
  parameter int OFF_W  = 12;
  parameter int VPN_W  = VA_W - OFF_W;
  parameter int PPN_W  = 20;
  parameter int ASID_W = 8;

  typedef struct packed {
    logic              vld;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic              wr;
    logic              used;
    logic              dirty;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match
  import tlb_pkg::*;
#(
  parameter int N     = 128,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tlb_ent_t          ent [N],
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);
  logic [N-1:0] hit_vec;

  // One comparator per entry: valid, page number and identifier must all agree.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent[g].vld && (ent[g].vpn == vpn) && (ent[g].asid == asid);
  end

  assign any = |hit_vec;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IDX_W'(i);
    end
  end

  // R2
  match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int N     = 128,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vld,
  input  logic [N-1:0]     used,
  output logic [IDX_W-1:0] idx,
  output logic             clr_used
);
  logic             have_inv;
  logic             have_unused;
  logic [IDX_W-1:0] inv_idx;
  logic [IDX_W-1:0] unused_idx;

  // Two priority encoders, lowest index wins in each.
  always_comb begin
    have_inv    = 1'b0;
    have_unused = 1'b0;
    inv_idx     = '0;
    unused_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        have_inv = 1'b1;
        inv_idx  = IDX_W'(i);
      end
      if (!used[i]) begin
        have_unused = 1'b1;
        unused_idx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    clr_used = 1'b0;
    if (have_inv) begin
      idx = inv_idx;
    end else if (have_unused) begin
      idx = unused_idx;
    end else begin
      idx      = '0;
      clr_used = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_asid_xlat.sv
module tlb_asid_xlat
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [ASID_W-1:0]      req_asid,
  input  logic                   req_write,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic [PPN_W+OFF_W-1:0] rsp_paddr,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_writable,
  input  logic                   inv_valid,
  input  logic                   inv_all,
  input  logic [ASID_W-1:0]      inv_asid,
  output logic                   evict_valid,
  output logic [VPN_W-1:0]       evict_vpn,
  output logic [ASID_W-1:0]      evict_asid,
  output logic                   evict_dirty
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PA_W  = PPN_W + OFF_W;

  tlb_ent_t ent_q [ENTRIES];
  tlb_ent_t ent_d [ENTRIES];
  logic [ENTRIES-1:0] vld_vec;
  logic [ENTRIES-1:0] used_vec;

  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  // Last-translation register
  logic              last_vld_q;
  logic [VPN_W-1:0]  last_vpn_q;
  logic [ASID_W-1:0] last_asid_q;
  logic [PPN_W-1:0]  last_ppn_q;
  logic              last_wr_q;
  logic [IDX_W-1:0]  last_idx_q;

  logic             cam_any;
  logic [IDX_W-1:0] cam_idx;
  logic [IDX_W-1:0] vict_idx;
  logic             clr_used;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
    assign vld_vec[g]  = ent_q[g].vld;
    assign used_vec[g] = ent_q[g].used;
  end

  tlb_cam_match #(.N(ENTRIES), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst_n(rst_n), .ent(ent_q), .vpn(req_vpn), .asid(req_asid),
    .any(cam_any), .idx(cam_idx)
  );

  tlb_victim_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .vld(vld_vec), .used(used_vec), .idx(vict_idx), .clr_used(clr_used)
  );

  // Lookup: a last-translation match bypasses the array result.
  logic             last_hit;
  logic             sel_any;
  logic [IDX_W-1:0] sel_idx;
  logic [PPN_W-1:0] sel_ppn;
  logic             sel_wr;
  logic             look_match;
  logic             look_fault;
  logic             look_hit;
  logic             fill_go;

  always_comb begin
    last_hit = last_vld_q && (last_vpn_q == req_vpn) && (last_asid_q == req_asid);
    if (last_hit) begin
      sel_any = 1'b1;
      sel_idx = last_idx_q;
      sel_ppn = last_ppn_q;
      sel_wr  = last_wr_q;
    end else begin
      sel_any = cam_any;
      sel_idx = cam_idx;
      sel_ppn = ent_q[cam_idx].ppn;
      sel_wr  = ent_q[cam_idx].wr;
    end
    look_match = req_valid && sel_any;
    look_fault = look_match && req_write && !sel_wr;
    look_hit   = look_match && !look_fault;
    fill_go    = fill_valid && !inv_valid;
  end

  // Entry next state: used clear, hit update, fill write, invalidate.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ent_d[i] = ent_q[i];
      if (fill_go && clr_used) ent_d[i].used = 1'b0;
      if (look_hit && (sel_idx == IDX_W'(i))) begin
        ent_d[i].used = 1'b1;
        if (req_write) ent_d[i].dirty = 1'b1;
      end
      if (fill_go && (vict_idx == IDX_W'(i))) begin
        ent_d[i].vld   = 1'b1;
        ent_d[i].vpn   = fill_vpn;
        ent_d[i].asid  = fill_asid;
        ent_d[i].ppn   = fill_ppn;
        ent_d[i].wr    = fill_writable;
        ent_d[i].used  = 1'b0;
        ent_d[i].dirty = 1'b0;
      end
      if (inv_valid && (inv_all || (ent_q[i].asid == inv_asid))) ent_d[i].vld = 1'b0;
    end
  end

  logic last_clr;
  logic last_load;
  assign last_clr  = inv_valid || fill_go;
  assign last_load = look_match && !last_clr;

  logic            evict_d;
  logic [PA_W-1:0] paddr_d;
  assign evict_d = fill_go && ent_q[vict_idx].vld;
  assign paddr_d = look_hit ? {sel_ppn, req_off} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld_q  <= 1'b0;
      last_vpn_q  <= '0;
      last_asid_q <= '0;
      last_ppn_q  <= '0;
      last_wr_q   <= 1'b0;
      last_idx_q  <= '0;
    end else if (last_clr) begin
      last_vld_q  <= 1'b0;
    end else if (last_load) begin
      last_vld_q  <= 1'b1;
      last_vpn_q  <= req_vpn;
      last_asid_q <= req_asid;
      last_ppn_q  <= sel_ppn;
      last_wr_q   <= sel_wr;
      last_idx_q  <= sel_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= look_hit;
      rsp_fault <= look_fault;
      rsp_paddr <= paddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_asid  <= '0;
      evict_dirty <= 1'b0;
    end else begin
      evict_valid <= evict_d;
      if (evict_d) begin
        evict_vpn   <= ent_q[vict_idx].vpn;
        evict_asid  <= ent_q[vict_idx].asid;
        evict_dirty <= ent_q[vict_idx].dirty;
      end
    end
  end

  // R7
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R5
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));
  // R6
  inv_clears_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !last_vld_q);
  // R7
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_valid) |=> (ent_q[$past(vict_idx)].vld &&
                                    ent_q[$past(vict_idx)].vpn == $past(fill_vpn)));
  // R10
  evict_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> ($past(fill_valid) && !$past(inv_valid)));
endmodule

// File: tb/tlb_asid_xlat_tb.sv
module tlb_asid_xlat_tb;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_writable = 1'b0;
  logic        inv_valid = 1'b0;
  logic        inv_all = 1'b0;
  logic [7:0]  inv_asid = '0;
  logic        evict_valid, evict_dirty;
  logic [19:0] evict_vpn;
  logic [7:0]  evict_asid;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  tlb_asid_xlat #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_asid(req_asid), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_ppn(fill_ppn),
    .fill_writable(fill_writable),
    .inv_valid(inv_valid), .inv_all(inv_all), .inv_asid(inv_asid),
    .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_asid(evict_asid),
    .evict_dirty(evict_dirty)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural associative model.
  bit          m_vld [N];
  bit [19:0]   m_vpn [N];
  bit [7:0]    m_asid [N];
  bit [19:0]   m_ppn [N];
  bit          m_wr [N];
  bit          m_used [N];
  bit          m_dirty [N];
  bit          e_valid, e_hit, e_fault, e_ev, e_evd;
  bit [31:0]   e_pa;
  bit [19:0]   e_evvpn;
  bit [7:0]    e_evasid;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vld[i] = 0; m_used[i] = 0; m_dirty[i] = 0;
      end
      e_valid = 0; e_hit = 0; e_fault = 0; e_pa = 0; e_ev = 0;
    end else begin
      int  mi;
      int  vi;
      bit  clr;
      bit  go;
      mi = -1;
      for (int i = 0; i < N; i++)
        if (m_vld[i] && m_vpn[i] == req_vaddr[31:12] && m_asid[i] == req_asid) mi = i;
      e_valid = req_valid;
      e_fault = req_valid && mi >= 0 && req_write && !m_wr[mi];
      e_hit   = req_valid && mi >= 0 && !e_fault;
      e_pa    = e_hit ? {m_ppn[mi], req_vaddr[11:0]} : 32'h0;
      go  = fill_valid && !inv_valid;
      vi  = -1;
      clr = 0;
      for (int i = 0; i < N; i++) if (vi < 0 && !m_vld[i]) vi = i;
      if (vi < 0) for (int i = 0; i < N; i++) if (vi < 0 && !m_used[i]) vi = i;
      if (vi < 0) begin vi = 0; clr = 1; end
      e_ev = go && m_vld[vi];
      if (e_ev) begin
        e_evvpn = m_vpn[vi]; e_evasid = m_asid[vi]; e_evd = m_dirty[vi];
      end
      if (go && clr) for (int i = 0; i < N; i++) m_used[i] = 0;
      if (e_hit) begin
        m_used[mi] = 1;
        if (req_write) m_dirty[mi] = 1;
      end
      if (go) begin
        m_vld[vi] = 1; m_vpn[vi] = fill_vpn; m_asid[vi] = fill_asid; m_ppn[vi] = fill_ppn;
        m_wr[vi] = fill_writable; m_used[vi] = 0; m_dirty[vi] = 0;
      end
      if (inv_valid)
        for (int i = 0; i < N; i++) if (inv_all || m_asid[i] == inv_asid) m_vld[i] = 0;
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (model_on) begin
      chk(rsp_valid == e_valid, "R7 rsp_valid", rsp_valid, e_valid);
      if (e_valid) begin
        chk(rsp_hit == e_hit, "R2 rsp_hit", rsp_hit, e_hit);
        chk(rsp_fault == e_fault, "R5 rsp_fault", rsp_fault, e_fault);
        chk(rsp_paddr == e_pa, "R1 rsp_paddr", rsp_paddr, e_pa);
      end
      chk(evict_valid == e_ev, "R9 evict_valid", evict_valid, e_ev);
      if (e_ev) begin
        chk(evict_vpn == e_evvpn, "R9 evict_vpn", evict_vpn, e_evvpn);
        chk(evict_asid == e_evasid, "R9 evict_asid", evict_asid, e_evasid);
        chk(evict_dirty == e_evd, "R3 evict_dirty", evict_dirty, e_evd);
      end
    end
  end

  task automatic do_look(input bit [31:0] va, input bit [7:0] asid, input bit wr,
                         input bit xh, input bit xf, input bit [31:0] xpa, input string tag);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_asid = asid; req_write = wr;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk(rsp_valid == 1'b1, {tag, " valid"}, rsp_valid, 1);
    chk(rsp_hit == xh, {tag, " hit"}, rsp_hit, xh);
    chk(rsp_fault == xf, {tag, " fault"}, rsp_fault, xf);
    chk(rsp_paddr == xpa, {tag, " paddr"}, rsp_paddr, xpa);
  endtask

  task automatic do_fill(input bit [19:0] vpn, input bit [7:0] asid, input bit [19:0] ppn,
                         input bit wr, input bit xev, input bit [19:0] xvpn, input bit xd,
                         input string tag);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn; fill_writable = wr;
    @(negedge clk);
    fill_valid = 0;
    chk(evict_valid == xev, {tag, " evict_valid"}, evict_valid, xev);
    if (xev) begin
      chk(evict_vpn == xvpn, {tag, " evict_vpn"}, evict_vpn, xvpn);
      chk(evict_dirty == xd, {tag, " evict_dirty"}, evict_dirty, xd);
    end
  endtask

  task automatic do_inv(input bit all, input bit [7:0] asid);
    @(negedge clk);
    inv_valid = 1; inv_all = all; inv_asid = asid;
    @(negedge clk);
    inv_valid = 0; inv_all = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(rsp_valid == 0, "R7 reset rsp_valid", rsp_valid, 0);
    chk(evict_valid == 0, "R7 reset evict_valid", evict_valid, 0);
    rst_n = 1;
    model_on = 1;

    // R7: fill then lookup in the very next cycle
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h12345; fill_asid = 8'd3; fill_ppn = 20'hABCDE; fill_writable = 1;
    @(negedge clk);
    fill_valid = 0;
    req_valid = 1; req_vaddr = 32'h12345678; req_asid = 8'd3; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_hit == 1 && rsp_paddr == 32'hABCDE678, "R7 fill visible next cycle", rsp_paddr, 32'hABCDE678);

    do_fill(20'h12345, 8'd4, 20'h00111, 0, 0, 0, 0, "R9 fill into free slot");
    do_fill(20'h00042, 8'd3, 20'h00777, 0, 0, 0, 0, "R9 fill into free slot");
    do_look(32'h12345678, 8'd3, 0, 1, 0, 32'hABCDE678, "R1 offset passthrough");
    do_look(32'h12345FFF, 8'd3, 0, 1, 0, 32'hABCDEFFF, "R6 repeated page");
    do_look(32'h12345001, 8'd4, 0, 1, 0, 32'h00111001, "R2 other identifier");
    do_look(32'h12345001, 8'd5, 0, 0, 0, 32'h0, "R2 unknown identifier miss");
    do_look(32'h12345001, 8'd4, 1, 0, 1, 32'h0, "R5 write to read-only");
    do_look(32'h12345002, 8'd4, 0, 1, 0, 32'h00111002, "R5 read of read-only");
    do_look(32'h12345010, 8'd3, 1, 1, 0, 32'hABCDE010, "R5 write to writable");
    do_inv(0, 8'd4);
    do_look(32'h12345001, 8'd4, 0, 0, 0, 32'h0, "R8 identifier cleared");
    do_look(32'h12345001, 8'd3, 0, 1, 0, 32'hABCDE001, "R8 other identifier kept");
    do_look(32'h00042123, 8'd3, 0, 1, 0, 32'h00777123, "R6 load last");
    do_inv(0, 8'd9);
    do_look(32'h00042124, 8'd3, 0, 1, 0, 32'h00777124, "R6 array after clear");
    do_inv(1, 8'd0);
    do_look(32'h00042124, 8'd3, 0, 0, 0, 32'h0, "R6 invalidated last misses");
    do_look(32'h12345124, 8'd3, 0, 0, 0, 32'h0, "R8 all cleared");

    // Fill the whole array under identifier 1. Entry 8 is read-only.
    for (int i = 0; i < N; i++)
      do_fill(20'(i), 8'd1, 20'(i + 'h100), (i != 8), 0, 0, 0, "R4 fill invalid slots");
    for (int i = 0; i < N; i++)
      if (i != 5) do_look({20'(i), 12'h004}, 8'd1, 0, 1, 0, {20'(i + 'h100), 12'h004}, "R4 read hit");
    do_look({20'd7, 12'h0}, 8'd1, 1, 1, 0, {20'h107, 12'h0}, "R3 write hit");
    do_look({20'd8, 12'h0}, 8'd1, 1, 0, 1, 32'h0, "R5 fault write");
    do_fill(20'h800, 8'd1, 20'h900, 1, 1, 20'd5, 0, "R4 lowest unused");
    do_fill(20'h900, 8'd1, 20'h901, 1, 1, 20'h800, 0, "R4 new entry unused");
    do_look({20'h900, 12'h0}, 8'd1, 0, 1, 0, {20'h901, 12'h0}, "R4 used set");
    do_fill(20'hA00, 8'd1, 20'hA01, 1, 1, 20'd0, 0, "R4 all used wraps to 0");
    do_look({20'hA00, 12'h0}, 8'd1, 0, 1, 0, {20'hA01, 12'h0}, "R4 used set");
    do_fill(20'hB00, 8'd1, 20'hB01, 1, 1, 20'd1, 0, "R4 after used clear");
    do_look({20'hB00, 12'h0}, 8'd1, 0, 1, 0, {20'hB01, 12'h0}, "R4 used set");
    for (int k = 0; k < 7; k++) begin
      int slot;
      slot = k + 2;
      do_fill(20'(32'hC00 + k), 8'd1, 20'(32'hC80 + k), 1, 1,
              (slot == 5) ? 20'h900 : 20'(slot), (slot == 7),
              (slot == 7) ? "R3 dirty eviction" : (slot == 8) ? "R5 fault left clean" : "R4 ordered eviction");
      do_look({20'(32'hC00 + k), 12'h0}, 8'd1, 0, 1, 0, {20'(32'hC80 + k), 12'h0}, "R4 used set");
    end

    // R10: fill and invalidate together
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'hD00; fill_asid = 8'd1; fill_ppn = 20'hD01; fill_writable = 1;
    inv_valid = 1; inv_all = 0; inv_asid = 8'd2;
    @(negedge clk);
    fill_valid = 0; inv_valid = 0;
    chk(evict_valid == 0, "R10 dropped fill no eviction", evict_valid, 0);
    do_look({20'hD00, 12'h0}, 8'd1, 0, 0, 0, 32'h0, "R10 dropped fill misses");
    do_look({20'hC00, 12'h0}, 8'd1, 0, 1, 0, {20'hC80, 12'h0}, "R8 other identifier invalidate");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule